// File: doc/BRIEF.md
# MSI Interrupt Request Generator

This block turns interrupt events into message-signalled interrupt requests. Three kinds of source feed it: numbered application interrupts, a hot-plug / power-management event and a system-error event. Each source is mapped onto one of the vectors that configuration has allocated. A vector that fires is recorded as a pending bit. While the per-vector mask bit for a vector is clear, its pending bit turns into one single-dword memory-write request. The request carries a ready-made header and payload, built from the configured message address, message data and requester ID.

Requests leave on a valid/ready stream, and only one request is outstanding at a time. A side port can overwrite one byte of the pending register at a time, for the function the block belongs to. Application interrupts are gated either by a per-vector enable word or by a single global enable, chosen by the `GLOBAL_EN` parameter. The default is per-vector.

Top module: `msi_req_gen`

## Requirements
- R1: After reset `req_valid` is 0 and `pend_bits` is all zeros.
- R2: Every request is a single-dword memory write. `req_hdr[31:0]` is header dword 0, with fmt in [31:29], traffic class in [22:20] and length 1 in [9:0]. Dword 1 carries first byte enables 1111 in `req_hdr[35:32]` and last byte enables 0000 in `req_hdr[39:36]`. When `cfg_addr64` is 0, fmt is 010 and `req_hdr[95:64]` is the address with bits [1:0] zero. When `cfg_addr64` is 1, fmt is 011, `req_hdr[95:64]` holds address bits [63:32] and `req_hdr[127:96]` holds the low address dword.
- R3: `req_data[15:0]` is the configured message data with its low log2(N) bits replaced by the vector number, where N is the allocated count. `req_data[31:16]` is zero.
- R4: N is 2 to the power of `cfg_mme`, and any value above 5 gives 32. A pending bit at vector N or above never produces a request.
- R5: With N=32, system error uses vector 31, hot-plug/power-management uses 30 and application interrupts use 29..0. With N=4 and `cfg_hp_share`=0, these are 3, 2 and 1..0. With N=4 and `cfg_hp_share`=1, system error and hot-plug/power-management both use 3, and application interrupts use 2..0.
- R6: An application interrupt number above the top application vector is folded onto that top application vector.
- R7: Requests for system error and hot-plug/power-management use traffic class 0. Application requests use the `app_irq_tc` given with the event.
- R8: While a vector's `cfg_mask` bit is 1, no request is issued for it and its pending bit stays set. When the mask bit clears and the block is idle, `req_valid` rises on the next clock edge.
- R9: Among pending, unmasked, allocated vectors, the lowest-numbered one is issued first. A request holds its header and data until it is accepted. The vector's pending bit clears on acceptance (valid and ready both high).
- R10: A pending write with `pnd_func` equal to `FUNC_ID` replaces pending byte `pnd_sel`, where 00 is bits [7:0], 01 is [15:8], 10 is [23:16] and 11 is [31:24]. A write with any other function number leaves `pend_bits` unchanged.
- R11: An application event whose vector is disabled in `app_vec_en` (default `GLOBAL_EN`=0) is dropped and sets no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mme | input | 3 | Allocated-count exponent |
| cfg_hp_share | input | 1 | Hot-plug/PM shares the system-error vector |
| cfg_msi_addr | input | 62 | Message address bits [63:2] |
| cfg_addr64 | input | 1 | Use a 4-dword header with 64-bit address |
| cfg_msi_data | input | 16 | Message data |
| cfg_req_id | input | 16 | Requester ID placed in the header |
| cfg_mask | input | 32 | Per-vector mask bits |
| app_irq_vld | input | 1 | Application interrupt strobe |
| app_irq_num | input | 5 | Requested application vector number |
| app_irq_tc | input | 3 | Traffic class for the application request |
| app_vec_en | input | 32 | Per-vector application enables |
| app_glb_en | input | 1 | Global application enable |
| hp_pm_evt | input | 1 | Hot-plug/power-management event strobe |
| sys_err_evt | input | 1 | System-error event strobe |
| pnd_wr | input | 1 | Pending byte write strobe |
| pnd_func | input | 3 | Function number of the pending write |
| pnd_sel | input | 2 | Pending byte select |
| pnd_byte | input | 8 | Pending byte value |
| pend_bits | output | 32 | Pending register |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by the consumer |
| req_hdr | output | 128 | Request header, dword 0 in the low bits |
| req_data | output | 32 | Request payload dword |

## Verification
An event seen at a clock edge shows in `pend_bits` right after that edge. Its request, if unmasked and the block is idle, is valid after the following edge. A mask clear that exposes a pending vector raises `req_valid` after the very next edge. After an acceptance there is one idle cycle before the next vector is issued. Stimulus changes on the falling edge, and the monitor samples 3 ns before each rising edge. It pops the expected item, in issue order, for every handshake it sees. Checks for masked, dropped or ignored events wait several cycles and then read `req_valid` and `pend_bits` at the ports.

// File: rtl/msi_req_pkg.sv
package msi_req_pkg;
  // Clamp the multiple-message exponent to the largest vector index width.
  function automatic logic [2:0] alloc_exp(input logic [2:0] mme, input int vw);
    alloc_exp = (int'(mme) > vw) ? 3'(vw) : mme;
  endfunction

  localparam logic [2:0] FMT_3DW_D = 3'b010;
  localparam logic [2:0] FMT_4DW_D = 3'b011;
  localparam logic [4:0] TYPE_MEM  = 5'b00000;
endpackage

// File: rtl/msi_vec_map.sv
module msi_vec_map #(
  parameter int VW  = 5,
  parameter int LGW = 3
) (
  input  logic [LGW-1:0] lg,
  input  logic           share,
  input  logic [VW-1:0]  app_num,
  output logic [VW-1:0]  sys_vec,
  output logic [VW-1:0]  hp_vec,
  output logic [VW-1:0]  app_vec
);
  logic [VW:0]   n_alloc;
  logic [VW-1:0] app_top;

  always_comb begin
    n_alloc = (VW+1)'(1) << lg;
    if (lg == '0) begin
      sys_vec = '0;
      hp_vec  = '0;
      app_top = '0;
    end else if (lg == LGW'(1)) begin
      sys_vec = VW'(1);
      hp_vec  = VW'(1);
      app_top = '0;
    end else begin
      sys_vec = VW'(n_alloc - 1);
      hp_vec  = share ? VW'(n_alloc - 1) : VW'(n_alloc - 2);
      app_top = share ? VW'(n_alloc - 2) : VW'(n_alloc - 3);
    end
    app_vec = (app_num > app_top) ? app_top : app_num;
  end
endmodule

// File: rtl/msi_pend_store.sv
module msi_pend_store #(
  parameter int NVEC = 32,
  parameter int VW   = 5,
  parameter int TCW  = 3,
  parameter int BSW  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sys_set,
  input  logic                      hp_set,
  input  logic                      app_set,
  input  logic [VW-1:0]             sys_vec,
  input  logic [VW-1:0]             hp_vec,
  input  logic [VW-1:0]             app_vec,
  input  logic [TCW-1:0]            app_tc,
  input  logic                      bw_en,
  input  logic [BSW-1:0]            bw_sel,
  input  logic [7:0]                bw_byte,
  input  logic                      clr_en,
  input  logic [VW-1:0]             clr_vec,
  output logic [NVEC-1:0]           pend,
  output logic [NVEC-1:0][TCW-1:0]  tc_arr
);
  logic [NVEC-1:0] pend_q, pend_d, set_sys, set_app;
  logic            pend_en;

  always_comb begin
    set_sys = '0;
    set_app = '0;
    if (sys_set) set_sys[sys_vec] = 1'b1;
    if (hp_set)  set_sys[hp_vec]  = 1'b1;
    if (app_set) set_app[app_vec] = 1'b1;
    pend_d = pend_q;
    if (clr_en) pend_d[clr_vec] = 1'b0;
    if (bw_en)  pend_d[{bw_sel, 3'b000} +: 8] = bw_byte;
    pend_d  = pend_d | set_sys | set_app;
    pend_en = clr_en | bw_en | (|set_sys) | (|set_app);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  // Traffic class per vector: hardware sources force class 0.
  for (genvar i = 0; i < NVEC; i++) begin : g_tc
    logic [TCW-1:0] tc_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tc_q <= '0;
      else if (set_sys[i]) tc_q <= '0;
      else if (set_app[i]) tc_q <= app_tc;
    end
    assign tc_arr[i] = tc_q;
  end

  assign pend = pend_q;
endmodule

// File: rtl/msi_lowest_pick.sv
module msi_lowest_pick #(
  parameter int NVEC = 32,
  parameter int VW   = 5
) (
  input  logic [NVEC-1:0] cand,
  output logic            found,
  output logic [VW-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NVEC-1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = VW'(i);
      end
    end
  end
endmodule

// File: rtl/msi_tlp_fmt.sv
module msi_tlp_fmt
  import msi_req_pkg::*;
#(
  parameter int TCW = 3
) (
  input  logic [63:2]    addr,
  input  logic           a64,
  input  logic [15:0]    req_id,
  input  logic [TCW-1:0] tc,
  output logic [127:0]   hdr
);
  logic [31:0] dw0, dw1, dw2, dw3;

  always_comb begin
    dw0 = {(a64 ? FMT_4DW_D : FMT_3DW_D), TYPE_MEM, 1'b0, 3'(tc), 4'b0000, 6'b000000, 10'd1};
    dw1 = {req_id, 8'h00, 4'b0000, 4'b1111};
    if (a64) begin
      dw2 = addr[63:32];
      dw3 = {addr[31:2], 2'b00};
    end else begin
      dw2 = {addr[31:2], 2'b00};
      dw3 = '0;
    end
    hdr = {dw3, dw2, dw1, dw0};
  end
endmodule

// File: rtl/msi_req_gen.sv
module msi_req_gen
  import msi_req_pkg::*;
#(
  parameter int          NVEC      = 32,
  parameter int          TCW       = 3,
  parameter logic [2:0]  FUNC_ID   = 3'd0,
  parameter bit          GLOBAL_EN = 1'b0,
  localparam int         VW        = $clog2(NVEC),
  localparam int         LGW       = $clog2(VW+1),
  localparam int         BSW       = $clog2(NVEC/8)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cfg_mme,
  input  logic            cfg_hp_share,
  input  logic [63:2]     cfg_msi_addr,
  input  logic            cfg_addr64,
  input  logic [15:0]     cfg_msi_data,
  input  logic [15:0]     cfg_req_id,
  input  logic [NVEC-1:0] cfg_mask,
  input  logic            app_irq_vld,
  input  logic [VW-1:0]   app_irq_num,
  input  logic [TCW-1:0]  app_irq_tc,
  input  logic [NVEC-1:0] app_vec_en,
  input  logic            app_glb_en,
  input  logic            hp_pm_evt,
  input  logic            sys_err_evt,
  input  logic            pnd_wr,
  input  logic [2:0]      pnd_func,
  input  logic [BSW-1:0]  pnd_sel,
  input  logic [7:0]      pnd_byte,
  output logic [NVEC-1:0] pend_bits,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [127:0]    req_hdr,
  output logic [31:0]     req_data
);
  logic [LGW-1:0]            lg;
  logic [VW:0]               n_alloc;
  logic [NVEC-1:0]           alloc_msk;
  logic [15:0]               low_msk;
  logic [VW-1:0]             sys_vec, hp_vec, app_vec, pick_idx;
  logic                      app_ok, pick_found, accept, load;
  logic [NVEC-1:0][TCW-1:0]  tc_arr;
  logic [127:0]              hdr_d;

  logic                      req_valid_q, req_valid_d;
  logic [VW-1:0]             req_vec_q;
  logic [127:0]              req_hdr_q;
  logic [31:0]               req_data_q, data_d;

  always_comb begin
    lg        = LGW'(alloc_exp(cfg_mme, VW));
    n_alloc   = (VW+1)'(1) << lg;
    alloc_msk = ~({NVEC{1'b1}} << n_alloc);
    low_msk   = 16'(n_alloc - 1);
  end

  msi_vec_map #(.VW(VW), .LGW(LGW)) u_map (
    .lg(lg), .share(cfg_hp_share), .app_num(app_irq_num),
    .sys_vec(sys_vec), .hp_vec(hp_vec), .app_vec(app_vec)
  );

  assign app_ok = GLOBAL_EN ? app_glb_en : app_vec_en[app_vec];
  assign accept = req_valid_q & req_ready;

  msi_pend_store #(.NVEC(NVEC), .VW(VW), .TCW(TCW), .BSW(BSW)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .sys_set(sys_err_evt), .hp_set(hp_pm_evt), .app_set(app_irq_vld & app_ok),
    .sys_vec(sys_vec), .hp_vec(hp_vec), .app_vec(app_vec), .app_tc(app_irq_tc),
    .bw_en(pnd_wr & (pnd_func == FUNC_ID)), .bw_sel(pnd_sel), .bw_byte(pnd_byte),
    .clr_en(accept), .clr_vec(req_vec_q),
    .pend(pend_bits), .tc_arr(tc_arr)
  );

  msi_lowest_pick #(.NVEC(NVEC), .VW(VW)) u_pick (
    .cand(pend_bits & ~cfg_mask & alloc_msk), .found(pick_found), .idx(pick_idx)
  );

  msi_tlp_fmt #(.TCW(TCW)) u_fmt (
    .addr(cfg_msi_addr), .a64(cfg_addr64), .req_id(cfg_req_id),
    .tc(tc_arr[pick_idx]), .hdr(hdr_d)
  );

  always_comb begin
    load        = ~req_valid_q & pick_found;
    req_valid_d = load | (req_valid_q & ~req_ready);
    data_d      = {16'h0000, (cfg_msi_data & ~low_msk) | (16'(pick_idx) & low_msk)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_valid_q <= 1'b0;
    else        req_valid_q <= req_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_vec_q  <= '0;
      req_hdr_q  <= '0;
      req_data_q <= '0;
    end else if (load) begin
      req_vec_q  <= pick_idx;
      req_hdr_q  <= hdr_d;
      req_data_q <= data_d;
    end
  end

  assign req_valid = req_valid_q;
  assign req_hdr   = req_hdr_q;
  assign req_data  = req_data_q;
endmodule

// File: rtl/msi_req_chk.sv
module msi_req_chk #(
  parameter int NVEC = 32,
  parameter int VW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      cfg_mme,
  input logic [NVEC-1:0] cfg_mask,
  input logic [NVEC-1:0] pend_bits,
  input logic            req_valid,
  input logic            req_ready,
  input logic [127:0]    req_hdr,
  input logic [31:0]     req_data,
  input logic [VW-1:0]   req_vec
);
  logic [VW:0]     n_now;
  logic [NVEC-1:0] alloc_now, below;

  always_comb begin
    n_now     = (VW+1)'(1) << ((int'(cfg_mme) > VW) ? VW : int'(cfg_mme));
    alloc_now = ~({NVEC{1'b1}} << n_now);
    below     = ~({NVEC{1'b1}} << req_vec);
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_hdr) && $stable(req_data));

  // R8
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> ((($past(cfg_mask)) >> req_vec) & NVEC'(1)) == '0);

  // R9
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> ($past(pend_bits & ~cfg_mask & alloc_now) & below) == '0);

  // R4
  alloc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (VW+1)'(req_vec) < n_now);

  // R2
  tlp_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_hdr[9:0] == 10'd1 && req_hdr[35:32] == 4'hF && req_hdr[39:36] == 4'h0);
endmodule

bind msi_req_gen msi_req_chk #(.NVEC(NVEC), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mme(cfg_mme), .cfg_mask(cfg_mask),
  .pend_bits(pend_bits), .req_valid(req_valid), .req_ready(req_ready),
  .req_hdr(req_hdr), .req_data(req_data), .req_vec(req_vec_q)
);

// File: tb/msi_req_gen_test.sv
`timescale 1ns/1ps
module msi_req_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_mme;
  logic        cfg_hp_share, cfg_addr64;
  logic [63:2] cfg_msi_addr;
  logic [15:0] cfg_msi_data, cfg_req_id;
  logic [31:0] cfg_mask, app_vec_en;
  logic        app_irq_vld, app_glb_en, hp_pm_evt, sys_err_evt, pnd_wr, req_ready;
  logic [4:0]  app_irq_num;
  logic [2:0]  app_irq_tc, pnd_func;
  logic [1:0]  pnd_sel;
  logic [7:0]  pnd_byte;
  logic [31:0] pend_bits, req_data;
  logic        req_valid;
  logic [127:0] req_hdr;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int          vec;
    logic [31:0] data;
    logic [2:0]  tc;
    logic        a64;
    logic [63:2] addr;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #5 clk = ~clk;

  msi_req_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_mme(cfg_mme), .cfg_hp_share(cfg_hp_share),
    .cfg_msi_addr(cfg_msi_addr), .cfg_addr64(cfg_addr64), .cfg_msi_data(cfg_msi_data),
    .cfg_req_id(cfg_req_id), .cfg_mask(cfg_mask), .app_irq_vld(app_irq_vld),
    .app_irq_num(app_irq_num), .app_irq_tc(app_irq_tc), .app_vec_en(app_vec_en),
    .app_glb_en(app_glb_en), .hp_pm_evt(hp_pm_evt), .sys_err_evt(sys_err_evt),
    .pnd_wr(pnd_wr), .pnd_func(pnd_func), .pnd_sel(pnd_sel), .pnd_byte(pnd_byte),
    .pend_bits(pend_bits), .req_valid(req_valid), .req_ready(req_ready),
    .req_hdr(req_hdr), .req_data(req_data)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int n_alloc();
    return 1 << ((cfg_mme > 3'd5) ? 5 : int'(cfg_mme));
  endfunction

  task automatic expect_req(input int vec, input logic [2:0] tc, input string tag);
    exp_t e;
    logic [15:0] lm;
    lm     = 16'(n_alloc() - 1);
    e.vec  = vec;
    e.data = {16'h0, (cfg_msi_data & ~lm) | (16'(vec) & lm)};
    e.tc   = tc;
    e.a64  = cfg_addr64;
    e.addr = cfg_msi_addr;
    e.tag  = tag;
    sbq.push_back(e);
  endtask

  task automatic app_evt(input int num, input logic [2:0] tc);
    app_irq_vld = 1'b1; app_irq_num = 5'(num); app_irq_tc = tc;
    tick(1);
    app_irq_vld = 1'b0;
  endtask

  task automatic src_evt(input bit sys);
    if (sys) sys_err_evt = 1'b1; else hp_pm_evt = 1'b1;
    tick(1);
    sys_err_evt = 1'b0; hp_pm_evt = 1'b0;
  endtask

  task automatic pnd_write(input logic [2:0] fn, input logic [1:0] sel, input logic [7:0] b);
    pnd_wr = 1'b1; pnd_func = fn; pnd_sel = sel; pnd_byte = b;
    tick(1);
    pnd_wr = 1'b0;
  endtask

  // Monitor: samples 3 ns before each rising edge; a handshake is taken there.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && req_valid && req_ready) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R9 unexpected request", 128'(req_data), 128'h0);
        end else begin
          exp_t e;
          logic [2:0] fmt;
          e   = sbq.pop_front();
          fmt = e.a64 ? 3'b011 : 3'b010;
          check(req_data == e.data, {e.tag, " data R3"}, 128'(req_data), 128'(e.data));
          check(req_hdr[22:20] == e.tc, {e.tag, " tc R7"}, 128'(req_hdr[22:20]), 128'(e.tc));
          check(req_hdr[31:29] == fmt && req_hdr[9:0] == 10'd1 && req_hdr[39:32] == 8'h0F,
                {e.tag, " shape R2"}, req_hdr[39:0], {88'h0, 8'h0F, fmt, 29'h1});
          if (e.a64)
            check(req_hdr[127:64] == {e.addr[31:2], 2'b00, e.addr[63:32]},
                  {e.tag, " addr64 R2"}, req_hdr[127:64], {e.addr[31:2], 2'b00, e.addr[63:32]});
          else
            check(req_hdr[95:64] == {e.addr[31:2], 2'b00},
                  {e.tag, " addr32 R2"}, req_hdr[95:64], {e.addr[31:2], 2'b00});
        end
      end
    end
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] hold_data;
    rst_n = 1'b0;
    cfg_mme = 3'd5; cfg_hp_share = 1'b0; cfg_addr64 = 1'b0;
    cfg_msi_addr = 62'h0000_0000_3FB8_0001; cfg_msi_data = 16'h5A40;
    cfg_req_id = 16'h0100; cfg_mask = '0; app_vec_en = '1; app_glb_en = 1'b0;
    app_irq_vld = 1'b0; app_irq_num = '0; app_irq_tc = '0;
    hp_pm_evt = 1'b0; sys_err_evt = 1'b0;
    pnd_wr = 1'b0; pnd_func = '0; pnd_sel = '0; pnd_byte = '0;
    req_ready = 1'b1;
    tick(3);
    check(req_valid == 1'b0, "R1 valid after reset", 128'(req_valid), 128'h0);
    check(pend_bits == '0, "R1 pending after reset", 128'(pend_bits), 128'h0);
    rst_n = 1'b1;
    tick(2);

    // 32 vectors: application, system error, hot-plug/PM
    expect_req(7, 3'd3, "R5 app7");   app_evt(7, 3'd3);  tick(4);
    expect_req(31, 3'd0, "R5 sys");   src_evt(1'b1);     tick(4);
    expect_req(30, 3'd0, "R5 hp");    src_evt(1'b0);     tick(4);
    // R6: number 31 folds onto vector 29
    expect_req(29, 3'd5, "R6 fold");  app_evt(31, 3'd5); tick(4);

    // R8: masked vector is held, released on mask clear
    cfg_mask = 32'h0000_0020;
    app_evt(5, 3'd1);
    tick(4);
    check(req_valid == 1'b0, "R8 masked no request", 128'(req_valid), 128'h0);
    check(pend_bits[5] == 1'b1, "R8 masked stays pending", 128'(pend_bits), 128'h20);
    expect_req(5, 3'd1, "R8 unmask");
    cfg_mask = '0;
    tick(1);
    check(req_valid == 1'b1, "R8 request one edge after unmask", 128'(req_valid), 128'h1);
    tick(4);
    check(pend_bits[5] == 1'b0, "R9 pending cleared on accept", 128'(pend_bits), 128'h0);

    // R9: lowest-numbered first
    cfg_mask = '1;
    app_evt(9, 3'd2); app_evt(3, 3'd4); app_evt(6, 3'd6);
    tick(2);
    check(pend_bits == 32'h0000_0248, "R9 three pending", 128'(pend_bits), 128'h248);
    expect_req(3, 3'd4, "R9 first");
    expect_req(6, 3'd6, "R9 second");
    expect_req(9, 3'd2, "R9 third");
    cfg_mask = '0;
    tick(10);

    // R9: held under back-pressure
    req_ready = 1'b0;
    expect_req(2, 3'd7, "R9 backpressure");
    app_evt(2, 3'd7);
    tick(2);
    hold_data = req_data;
    tick(4);
    check(req_valid == 1'b1 && req_data == hold_data, "R9 held while not ready",
          128'(req_data), 128'(hold_data));
    req_ready = 1'b1;
    tick(4);

    // R10: pending byte writes
    cfg_mask = '1;
    pnd_write(3'd0, 2'b10, 8'h01);
    tick(1);
    check(pend_bits == 32'h0001_0000, "R10 byte 2 write", 128'(pend_bits), 128'h10000);
    pnd_write(3'd1, 2'b00, 8'hFF);
    tick(2);
    check(pend_bits == 32'h0001_0000, "R10 other function ignored", 128'(pend_bits), 128'h10000);
    pnd_write(3'd0, 2'b11, 8'h80);
    tick(1);
    check(pend_bits == 32'h8001_0000, "R10 byte 3 write", 128'(pend_bits), 128'h80010000);
    pnd_write(3'd0, 2'b11, 8'h00);
    expect_req(16, 3'd0, "R10 written vector");
    cfg_mask = '0;
    tick(6);

    // R11: disabled application vector is dropped
    app_vec_en = 32'hFFFF_FFFE;
    app_evt(0, 3'd1);
    tick(4);
    check(pend_bits[0] == 1'b0 && req_valid == 1'b0, "R11 disabled dropped",
          128'(pend_bits), 128'h0);
    app_vec_en = '1;

    // R2: 64-bit address
    cfg_addr64 = 1'b1; cfg_msi_addr = 62'h1234_5678_0ABC_DEF1;
    expect_req(12, 3'd0, "R2 a64"); app_evt(12, 3'd0); tick(4);
    cfg_addr64 = 1'b0;

    // 4 vectors, separate hot-plug vector
    cfg_mme = 3'd2;
    expect_req(3, 3'd0, "R5 n4 sys"); src_evt(1'b1);     tick(4);
    expect_req(2, 3'd0, "R5 n4 hp");  src_evt(1'b0);     tick(4);
    expect_req(1, 3'd6, "R6 n4 fold"); app_evt(5, 3'd6); tick(4);
    // shared hot-plug
    cfg_hp_share = 1'b1;
    expect_req(3, 3'd0, "R5 n4 share hp"); src_evt(1'b0);     tick(4);
    expect_req(2, 3'd3, "R5 n4 share app"); app_evt(9, 3'd3); tick(4);
    // R4: pending above allocated count is never issued
    pnd_write(3'd0, 2'b01, 8'h01);
    tick(5);
    check(pend_bits[8] == 1'b1 && req_valid == 1'b0, "R4 beyond allocation idle",
          128'(pend_bits), 128'h100);
    // R4: exponent 7 behaves as 32 vectors, so vector 8 now goes out
    cfg_mme = 3'd7;
    expect_req(8, 3'd0, "R4 mme7");
    tick(6);

    check(sbq.size() == 0, "R9 all expected requests seen", 128'(sbq.size()), 128'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule